// File: doc/BRIEF.md
# Clock-Synchronous Serial Slave Port with Busy Handshake

This block is the device side of a four-wire synchronous serial link. An external master supplies the transfer clock. It sends bytes on a receive line and collects bytes from a transmit line. A busy output tells the master when it may start the next byte. The block samples the external clock and the receive line with its own system clock and detects the clock edges. It collects each incoming byte into a parallel word with a one-cycle strobe. It also shifts out a byte that the core has loaded beforehand.

Both directions move 8 bits per byte, least significant bit first. The external clock idles high. Each bit period begins with a falling edge, on which the slave drives its transmit bit. It ends with a rising edge, on which the slave samples the receive bit. Busy stays high in four cases: while a byte is in flight, while a received byte waits for the core to acknowledge it, while the core reports a long operation, and for the first cycle after reset. Clock edges that arrive while busy is high, outside a byte already in progress, are discarded.

Top module: `clksync_serial_slave`

## Requirements
- R1: After the eighth rising edge of a byte, `rx_valid` is high for exactly one system clock. `rx_data` then holds the received byte, with the first bit on the line in bit 0 and the last in bit 7.
- R2: A byte loaded with `tx_valid` is driven on `sdo` one bit per falling edge, bit 0 first. `sdo` keeps the last bit driven until the next falling edge of a byte, and it is never unknown.
- R3: When the block is idle, `busy` is low. Once a byte has started with its first falling edge, `busy` is high before the first rising edge of that byte.
- R4: After a byte is received, `busy` stays high until `rx_ack` is pulsed. It goes low on the clock after the acknowledge, if nothing else holds it high.
- R5: While `core_busy` is high, `busy` is high from the next system clock onward. `busy` goes low only after `core_busy` has dropped and no acknowledge is outstanding.
- R6: Clock edges seen while `busy` is high, with no byte in progress, change neither `rx_valid`, `rx_data`, `sdo` nor the bit position of the next byte.
- R7: Synchronous reset makes `busy` high, `rx_valid` low, `rx_data` zero and `sdo` low. It discards any partial byte, and `busy` falls on the first clock after reset is released.
- R8: A `tx_valid` that arrives while a byte is in progress is ignored. The byte on the line keeps the bits that were loaded before it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the transfer clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | External transfer clock, idles high |
| sdi | input | 1 | Serial receive line |
| sdo | output | 1 | Serial transmit line, always driven |
| busy | output | 1 | High when the master must not start a byte |
| core_busy | input | 1 | Core request to hold busy high |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` |
| rx_ack | input | 1 | Core acknowledge of the received byte |
| tx_data | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | Load strobe for `tx_data` |

## Verification
Two conditions can hold `busy` high in the same cycle: the acknowledge of a received byte that is still outstanding, and the core's own busy request. The bench overlaps them three ways. In the first, the acknowledge arrives while the core is still busy. In the second, the core request drops while the acknowledge is still outstanding. In the third, the acknowledge and the drop of the core request fall on the same system clock. In each case `busy` must stay high until the later of the two has cleared and fall exactly one clock after it. A byte clocked in while busy is held must leave no trace on the next real byte.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Events seen on the external link after synchronization.
  typedef struct packed {
    logic rise;
    logic fall;
    logic din;
  } ssp_edges_t;

  // Decoded per-cycle actions issued by the control stage.
  typedef struct packed {
    logic start;     // first accepted falling edge of a byte
    logic shift_rx;  // accepted rising edge
    logic shift_tx;  // accepted falling edge
    logic done;      // last rising edge of a byte
    logic load_ok;   // parallel load of transmit byte allowed
  } ssp_ctl_t;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync
  import ssp_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_in,
  input  logic       sdi,
  output ssp_edges_t ev
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] ck_q;
  logic [LAST:0] dt_q;
  logic          ck_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            ck_q[g] <= 1'b1;
            dt_q[g] <= 1'b0;
          end else begin
            ck_q[g] <= sclk_in;
            dt_q[g] <= sdi;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            ck_q[g] <= 1'b1;
            dt_q[g] <= 1'b0;
          end else begin
            ck_q[g] <= ck_q[g-1];
            dt_q[g] <= dt_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ck_prev <= 1'b1;
    else     ck_prev <= ck_q[LAST];
  end

  always_comb begin
    ev.rise = ck_q[LAST] & ~ck_prev;
    ev.fall = ~ck_q[LAST] & ck_prev;
    ev.din  = dt_q[LAST];
  end

endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  ssp_edges_t ev,
  input  logic       core_busy,
  input  logic       rx_ack,
  output ssp_ctl_t   ctl,
  output logic       in_prog,
  output logic       busy
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic             pend_q;
  logic             in_prog_d;
  logic             pend_d;

  always_comb begin
    ctl.start    = ev.fall & ~in_prog & ~busy;
    ctl.shift_rx = ev.rise & in_prog;
    ctl.shift_tx = ctl.start | (ev.fall & in_prog);
    ctl.done     = ctl.shift_rx & (bit_cnt == LAST_BIT);
    ctl.load_ok  = ~in_prog & ~ctl.start;

    in_prog_d = in_prog;
    if (ctl.start)     in_prog_d = 1'b1;
    else if (ctl.done) in_prog_d = 1'b0;

    pend_d = ctl.done | (pend_q & ~rx_ack);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      in_prog <= 1'b0;
      pend_q  <= 1'b0;
      busy    <= 1'b1;
    end else begin
      if (ctl.start)         bit_cnt <= '0;
      else if (ctl.shift_rx) bit_cnt <= bit_cnt + 1'b1;
      in_prog <= in_prog_d;
      pend_q  <= pend_d;
      busy    <= in_prog_d | pend_d | core_busy;
    end
  end

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ssp_edges_t        ev,
  input  ssp_ctl_t          ctl,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {ev.din, sh_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= ctl.done;
      if (ctl.start)    sh_q <= '0;
      if (ctl.shift_rx) sh_q <= sh_next;
      if (ctl.done)     rx_data <= sh_next;
    end
  end

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ssp_ctl_t          ctl,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              sdo
);

  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      sdo  <= 1'b0;
    end else if (ctl.shift_tx) begin
      sdo  <= sh_q[0];
      sh_q <= {1'b0, sh_q[DATA_W-1:1]};
    end else if (tx_valid && ctl.load_ok) begin
      sh_q <= tx_data;
    end
  end

endmodule

// File: rtl/clksync_serial_slave.sv
module clksync_serial_slave
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              sdi,
  output logic              sdo,
  output logic              busy,
  input  logic              core_busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ack,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid
);

  ssp_edges_t ev;
  ssp_ctl_t   ctl;
  logic       in_prog;

  ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sclk_in (sclk_in),
    .sdi     (sdi),
    .ev      (ev)
  );

  ssp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .core_busy (core_busy),
    .rx_ack    (rx_ack),
    .ctl       (ctl),
    .in_prog   (in_prog),
    .busy      (busy)
  );

  ssp_rx #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .ctl      (ctl),
    .rx_data  (rx_data),
    .rx_valid (rx_valid)
  );

  ssp_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .sdo      (sdo)
  );

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic core_busy,
  input logic rx_valid,
  input logic sdo,
  input logic in_prog
);

  // R1
  rx_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4
  rx_pending_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> busy);

  // R3
  byte_active_busy_chk: assert property (@(posedge clk) disable iff (rst)
    in_prog |-> busy);

  // R5
  core_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    core_busy |=> busy);

  // R5
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !$past(core_busy));

  // R2
  sdo_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(sdo));

endmodule

bind clksync_serial_slave ssp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .core_busy (core_busy),
  .rx_valid  (rx_valid),
  .sdo       (sdo),
  .in_prog   (in_prog)
);

// File: tb/clksync_serial_slave_tb.sv
`timescale 1ns/1ps
module clksync_serial_slave_tb;

  localparam int HALF = 8;
  localparam int NV   = 6;
  // {rx byte sent by master, tx byte loaded by core}
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_3C, 16'h00_FF, 16'hFF_00, 16'h81_7E, 16'h5A_C3, 16'h01_80
  };

  logic clk = 1'b0, rst = 1'b1, sclk_in = 1'b1, sdi = 1'b0;
  logic core_busy = 1'b0, rx_ack = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sdo, busy, rx_valid;
  logic [7:0] rx_data;

  int n_chk = 0, n_fail = 0, rxv_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  clksync_serial_slave u_dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdi(sdi), .sdo(sdo),
    .busy(busy), .core_busy(core_busy), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ack(rx_ack), .tx_data(tx_data),
    .tx_valid(tx_valid)
  );

  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      rxv_cnt++;
      rx_last = rx_data;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic load_tx(input logic [7:0] b);
    @(negedge clk); tx_data = b; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
  endtask

  task automatic run_byte(input logic [7:0] mosi, input logic [7:0] miso,
                          input bit chk_miso, input bit chk_busy, input bit inject,
                          input int nbits);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); sclk_in = 1'b0; sdi = mosi[i];
      repeat (HALF) @(negedge clk);
      if (chk_busy && i == 0) chk("R3 busy high after first fall", {7'b0, busy}, 8'h01);
      if (inject && i == 3) begin
        tx_data = ~miso; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
      end
      if (chk_miso) chk(inject ? "R8 sdo bit" : "R2 sdo bit", {7'b0, sdo}, {7'b0, miso[i]});
      sclk_in = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 50 && busy; k++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int c0;
    // R7 reset state
    repeat (3) @(negedge clk);
    chk("R7 busy in reset", {7'b0, busy}, 8'h01);
    chk("R7 rx_valid in reset", {7'b0, rx_valid}, 8'h00);
    chk("R7 sdo in reset", {7'b0, sdo}, 8'h00);
    chk("R7 rx_data in reset", rx_data, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 busy falls after reset", {7'b0, busy}, 8'h00);

    // Vector table: R1 R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      wait_idle();
      chk("R3 idle busy low", {7'b0, busy}, 8'h00);
      load_tx(VEC[v][7:0]);
      c0 = rxv_cnt;
      run_byte(VEC[v][15:8], VEC[v][7:0], 1'b1, 1'b1, 1'b0, 8);
      chk("R1 one strobe", 8'(rxv_cnt - c0), 8'h01);
      chk("R1 rx byte", rx_last, VEC[v][15:8]);
      chk("R1 rx_data held", rx_data, VEC[v][15:8]);
      repeat (20) @(negedge clk);
      chk("R4 busy held until ack", {7'b0, busy}, 8'h01);
      chk("R2 sdo holds last bit", {7'b0, sdo}, {7'b0, VEC[v][7]});
      pulse_ack();
      chk("R4 busy low after ack", {7'b0, busy}, 8'h00);
    end

    // R6 edges ignored while an acknowledge is outstanding
    wait_idle();
    load_tx(8'h96);
    run_byte(8'h3D, 8'h96, 1'b0, 1'b0, 1'b0, 8);
    c0 = rxv_cnt;
    run_byte(8'hC2, 8'h00, 1'b0, 1'b0, 1'b0, 8);
    chk("R6 no strobe while pending", 8'(rxv_cnt - c0), 8'h00);
    chk("R6 rx_data untouched", rx_data, 8'h3D);
    chk("R6 sdo untouched", {7'b0, sdo}, 8'h01);
    pulse_ack();

    // R6 / R5 edges ignored while core busy, next byte aligned
    @(negedge clk); core_busy = 1'b1;
    @(negedge clk);
    chk("R5 busy follows core", {7'b0, busy}, 8'h01);
    c0 = rxv_cnt;
    run_byte(8'h0F, 8'h00, 1'b0, 1'b0, 1'b0, 5);
    chk("R6 no strobe under core busy", 8'(rxv_cnt - c0), 8'h00);
    core_busy = 1'b0;
    @(negedge clk);
    chk("R5 busy low after core", {7'b0, busy}, 8'h00);
    load_tx(8'h5C);
    c0 = rxv_cnt;
    run_byte(8'hE7, 8'h5C, 1'b1, 1'b1, 1'b0, 8);
    chk("R6 next byte aligned", rx_last, 8'hE7);
    chk("R6 one strobe", 8'(rxv_cnt - c0), 8'h01);

    // Overlap A: ack while core busy
    @(negedge clk); core_busy = 1'b1;
    pulse_ack();
    chk("R5 ack under core busy", {7'b0, busy}, 8'h01);
    core_busy = 1'b0;
    @(negedge clk);
    chk("R5 release after core", {7'b0, busy}, 8'h00);

    // Overlap B: core drops while ack outstanding
    run_byte(8'h44, 8'h00, 1'b0, 1'b1, 1'b0, 8);
    @(negedge clk); core_busy = 1'b1;
    @(negedge clk); core_busy = 1'b0;
    @(negedge clk);
    chk("R4 pending outlives core", {7'b0, busy}, 8'h01);
    pulse_ack();
    chk("R4 release on ack", {7'b0, busy}, 8'h00);

    // Overlap C: ack and core release in the same cycle
    run_byte(8'h22, 8'h00, 1'b0, 1'b1, 1'b0, 8);
    @(negedge clk); core_busy = 1'b1;
    @(negedge clk); rx_ack = 1'b1; core_busy = 1'b0;
    @(negedge clk); rx_ack = 1'b0;
    chk("R5 same-cycle release", {7'b0, busy}, 8'h00);

    // R8 tx_valid during a byte ignored
    load_tx(8'h3C);
    run_byte(8'h99, 8'h3C, 1'b1, 1'b1, 1'b1, 8);
    chk("R8 rx ok", rx_last, 8'h99);
    pulse_ack();

    // R7 reset mid-byte
    load_tx(8'hF0);
    run_byte(8'h07, 8'h00, 1'b0, 1'b0, 1'b0, 3);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R7 busy on mid-byte reset", {7'b0, busy}, 8'h01);
    chk("R7 sdo cleared", {7'b0, sdo}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    load_tx(8'hB4);
    c0 = rxv_cnt;
    run_byte(8'h6B, 8'hB4, 1'b1, 1'b1, 1'b0, 8);
    chk("R7 fresh byte after reset", rx_last, 8'h6B);
    chk("R7 one strobe after reset", 8'(rxv_cnt - c0), 8'h01);
    pulse_ack();

    finish_run();
  end

endmodule